// File: doc/BRIEF.md
# Destination Address Screen

This block decides, for every received Ethernet frame, whether the frame is to be kept, judging only by its 48-bit destination address. The receive path presents the address with a one-cycle strobe. One clock later the block reports a keep/drop verdict and a two-bit code that says which rule admitted the frame. The address is carried with byte 0 in bits 7:0, byte 1 in bits 15:8, and so on up to byte 5 in bits 47:40.

Four rule families can admit a frame. The first is an exact match against one of a set of configured station addresses. The second is the broadcast address. The third is a hit in a 64-entry hash table. The last is a pass-everything mode. A no-broadcast switch can veto the broadcast address. Separate switches decide whether the hash table is consulted for group addresses, for individual addresses, or for both. Frame parsing and CRC checking happen elsewhere.

Top module: `dst_addr_screen`

## Requirements
- R1: While reset is applied, and after it is released, `dec_valid`, `dec_accept` and `dec_reason` are all 0 until an address is strobed. Reset acts asynchronously. Its release is synchronised over two clocks.
- R2: A strobe on `dst_valid` at a rising edge yields `dec_valid` = 1 for exactly the following cycle. Back-to-back strobes yield back-to-back verdicts. When `dec_valid` is 0, `dec_accept` and `dec_reason` are 0.
- R3: With `mode_copy_all` = 1, every address is accepted with reason 3 (copy-all). This includes the broadcast address when `mode_no_bcast` is set.
- R4: Station `n` is programmed in two words. The low word (`sta_lo_words[32n+31:32n]`) holds byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. The high word (`sta_hi_words[16n+15:16n]`) holds byte 4 in bits 7:0 and byte 5 in 15:8. An address equal to any enabled station is accepted with reason 0 (station).
- R5: A station whose low and high words are both zero is disabled and never matches, not even the all-zero address.
- R6: The all-ones address is accepted with reason 1 (broadcast) when `mode_no_bcast` = 0. It is rejected when `mode_no_bcast` = 1 and copy-all is off, even if the hash table would admit it.
- R7: The hash index is 6 bits wide. Address bit p is bit (p mod 8) of byte (p div 8), for p = 0 to 47. Index bit k is the XOR of all address bits whose position p satisfies p mod 6 = k. Index values 0 to 31 select bit `hash_lo[idx]`. Values 32 to 63 select bit `hash_hi[idx-32]`.
- R8: The group bit is bit 0 of byte 0 (`dst_addr[0]`). With `mode_mc_hash` = 1, a group address whose table bit is 1 is accepted with reason 2 (hash).
- R9: With `mode_uc_hash` = 1, an individual address (group bit 0) whose table bit is 1 is accepted with reason 2. `mode_mc_hash` alone does not admit individual addresses. `mode_uc_hash` alone does not admit group addresses.
- R10: With both hash enables off, a set table bit admits nothing. A table set to all ones admits every group address when `mode_mc_hash` = 1.
- R11: When several rules admit the same address, the reason is chosen in this order: copy-all, then station, then broadcast, then hash. An address admitted by no rule gives `dec_accept` = 0 and `dec_reason` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| sta_lo_words | input | 32*NUM_STATION | Station low words, bytes 0..3 |
| sta_hi_words | input | 16*NUM_STATION | Station high words, bytes 4..5 |
| hash_lo | input | 32 | Hash table bits for index 0..31 |
| hash_hi | input | 32 | Hash table bits for index 32..63 |
| mode_copy_all | input | 1 | Accept every address |
| mode_mc_hash | input | 1 | Hash test for group addresses |
| mode_uc_hash | input | 1 | Hash test for individual addresses |
| mode_no_bcast | input | 1 | Reject the all-ones address |
| dec_valid | output | 1 | Verdict present |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 2 | 0 station, 1 broadcast, 2 hash, 3 copy-all |

## Verification
Several rules can claim the same address in the same cycle. Examples are a station address whose table bit is set, the broadcast address under an all-ones hash table, and copy-all on a station or vetoed broadcast address. The bench builds these collisions on purpose by loading the table either with only the bit the address indexes or with every other bit. It then checks that the reason code follows the stated priority. It also checks that the broadcast veto beats a table hit. Every table entry is derived in the bench from the bit-position rule, independently of the design.

// File: rtl/dstf_pkg.sv
package dstf_pkg;

  localparam int ADDR_W   = 48;
  localparam int STA_LO_W = 32;
  localparam int STA_HI_W = 16;

  typedef enum logic [1:0] {
    RSN_STATION = 2'd0,
    RSN_BCAST   = 2'd1,
    RSN_HASH    = 2'd2,
    RSN_COPYALL = 2'd3
  } reason_e;

  typedef struct packed {
    logic copy_all;
    logic mc_hash;
    logic uc_hash;
    logic no_bcast;
  } mode_t;

  typedef struct packed {
    logic    accept;
    reason_e reason;
  } verdict_t;

endpackage

// File: rtl/dstf_hash_index.sv
module dstf_hash_index #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  // Index bit k folds every address bit whose position is congruent to k modulo IDX_W.
  for (genvar k = 0; k < IDX_W; k++) begin : g_fold
    logic fold_bit;
    always_comb begin
      fold_bit = 1'b0;
      for (int p = k; p < ADDR_W; p += IDX_W) begin
        fold_bit = fold_bit ^ addr[p];
      end
    end
    assign idx[k] = fold_bit;
  end

endmodule

// File: rtl/dstf_hash_lookup.sv
module dstf_hash_lookup #(
  parameter int IDX_W = 6,
  localparam int TABLE_W = 1 << IDX_W,
  localparam int HALF_W  = TABLE_W / 2
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] table_lo,
  input  logic [HALF_W-1:0] table_hi,
  output logic              hit
);

  logic [TABLE_W-1:0] table_all;

  assign table_all = {table_hi, table_lo};

  always_comb begin
    hit = table_all[idx];
  end

endmodule

// File: rtl/dstf_station_cmp.sv
module dstf_station_cmp
  import dstf_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic [STA_LO_W-1:0] word_lo,
  input  logic [STA_HI_W-1:0] word_hi,
  output logic                hit
);

  logic [ADDR_W-1:0] station;
  logic              enabled;

  // Byte 0 sits in the least significant position of both the address and the low word.
  assign station = {word_hi, word_lo};
  assign enabled = |station;

  always_comb begin
    hit = enabled && (station == addr);
  end

endmodule

// File: rtl/dstf_decide.sv
module dstf_decide
  import dstf_pkg::*;
(
  input  mode_t    mode,
  input  logic     station_hit,
  input  logic     is_bcast,
  input  logic     is_group,
  input  logic     table_hit,
  output verdict_t verdict
);

  logic hash_armed;

  assign hash_armed = is_group ? mode.mc_hash : mode.uc_hash;

  always_comb begin
    verdict = '{accept: 1'b0, reason: RSN_STATION};
    if (mode.copy_all) begin
      verdict = '{accept: 1'b1, reason: RSN_COPYALL};
    end else if (is_bcast && mode.no_bcast) begin
      verdict = '{accept: 1'b0, reason: RSN_STATION};
    end else if (station_hit) begin
      verdict = '{accept: 1'b1, reason: RSN_STATION};
    end else if (is_bcast) begin
      verdict = '{accept: 1'b1, reason: RSN_BCAST};
    end else if (hash_armed && table_hit) begin
      verdict = '{accept: 1'b1, reason: RSN_HASH};
    end
  end

endmodule

// File: rtl/dst_addr_screen.sv
module dst_addr_screen
  import dstf_pkg::*;
#(
  parameter int NUM_STATION = 4,
  parameter int IDX_W       = 6,
  localparam int TABLE_W = 1 << IDX_W,
  localparam int HALF_W  = TABLE_W / 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            dst_valid,
  input  logic [ADDR_W-1:0]               dst_addr,
  input  logic [NUM_STATION*STA_LO_W-1:0] sta_lo_words,
  input  logic [NUM_STATION*STA_HI_W-1:0] sta_hi_words,
  input  logic [HALF_W-1:0]               hash_lo,
  input  logic [HALF_W-1:0]               hash_hi,
  input  logic                            mode_copy_all,
  input  logic                            mode_mc_hash,
  input  logic                            mode_uc_hash,
  input  logic                            mode_no_bcast,
  output logic                            dec_valid,
  output logic                            dec_accept,
  output logic [1:0]                      dec_reason
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  // Address classification.
  logic                   is_bcast;
  logic                   is_group;
  logic [IDX_W-1:0]       hash_idx;
  logic                   table_hit;
  logic [NUM_STATION-1:0] sta_hit;
  logic                   station_any;
  mode_t                  mode;
  verdict_t               verdict;

  assign is_bcast    = &dst_addr;
  assign is_group    = dst_addr[0];
  assign station_any = |sta_hit;
  assign mode        = '{copy_all: mode_copy_all, mc_hash: mode_mc_hash,
                         uc_hash: mode_uc_hash, no_bcast: mode_no_bcast};

  dstf_hash_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
    .addr (dst_addr),
    .idx  (hash_idx)
  );

  dstf_hash_lookup #(.IDX_W(IDX_W)) u_lookup (
    .idx      (hash_idx),
    .table_lo (hash_lo),
    .table_hi (hash_hi),
    .hit      (table_hit)
  );

  for (genvar g = 0; g < NUM_STATION; g++) begin : g_sta
    dstf_station_cmp u_cmp (
      .addr    (dst_addr),
      .word_lo (sta_lo_words[g*STA_LO_W +: STA_LO_W]),
      .word_hi (sta_hi_words[g*STA_HI_W +: STA_HI_W]),
      .hit     (sta_hit[g])
    );

    // R5: a station programmed as all zeros never reports a hit.
    p_zero_station_r5 : assert property (@(posedge clk) disable iff (!rst_l)
      (dst_valid && ({sta_hi_words[g*STA_HI_W +: STA_HI_W],
                      sta_lo_words[g*STA_LO_W +: STA_LO_W]} == '0)) |-> !sta_hit[g]);
  end

  dstf_decide u_decide (
    .mode        (mode),
    .station_hit (station_any),
    .is_bcast    (is_bcast),
    .is_group    (is_group),
    .table_hit   (table_hit),
    .verdict     (verdict)
  );

  // Output stage: next state and register kept apart.
  logic       out_en;
  logic       valid_d,  valid_q;
  logic       accept_d, accept_q;
  logic [1:0] reason_d, reason_q;

  assign out_en = dst_valid | valid_q;

  always_comb begin
    valid_d  = dst_valid;
    accept_d = dst_valid & verdict.accept;
    reason_d = dst_valid ? verdict.reason : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      reason_q <= 2'd0;
    end else if (out_en) begin
      valid_q  <= valid_d;
      accept_q <= accept_d;
      reason_q <= reason_d;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_accept = accept_q;
  assign dec_reason = reason_q;

  // R2: one verdict per strobe, in the next cycle only.
  p_verdict_follows_r2 : assert property (@(posedge clk) disable iff (!rst_l)
    dst_valid |=> dec_valid);
  p_verdict_single_r2 : assert property (@(posedge clk) disable iff (!rst_l)
    !dst_valid |=> !dec_valid);
  p_idle_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_l)
    !dec_valid |-> (!dec_accept && dec_reason == 2'd0));

  // R3: copy-all admits everything.
  p_copy_all_r3 : assert property (@(posedge clk) disable iff (!rst_l)
    (dst_valid && mode_copy_all) |=> (dec_accept && dec_reason == 2'd3));

  // R6: the broadcast veto holds against every rule except copy-all.
  p_bcast_veto_r6 : assert property (@(posedge clk) disable iff (!rst_l)
    (dst_valid && is_bcast && mode_no_bcast && !mode_copy_all) |=> !dec_accept);

  // R10: a full table admits every group address when the group hash is on.
  p_full_table_r10 : assert property (@(posedge clk) disable iff (!rst_l)
    (dst_valid && dst_addr[0] && mode_mc_hash && !mode_no_bcast
     && (&hash_lo) && (&hash_hi)) |=> dec_accept);

  // R11: unmatched addresses are dropped with a zero reason.
  p_no_rule_r11 : assert property (@(posedge clk) disable iff (!rst_l)
    (dst_valid && !mode_copy_all && !station_any && !is_bcast
     && !mode_mc_hash && !mode_uc_hash) |=> (!dec_accept && dec_reason == 2'd0));

endmodule

// File: tb/sim_dst_addr_screen.sv
`timescale 1ns/1ps
module sim_dst_addr_screen;

  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dst_valid;
  logic [47:0]   dst_addr;
  logic [NS*32-1:0] sta_lo_words;
  logic [NS*16-1:0] sta_hi_words;
  logic [31:0]   hash_lo, hash_hi;
  logic          mode_copy_all, mode_mc_hash, mode_uc_hash, mode_no_bcast;
  logic          dec_valid, dec_accept;
  logic [1:0]    dec_reason;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dst_addr_screen #(.NUM_STATION(NS), .IDX_W(6)) u0 (
    .clk, .rst_n, .dst_valid, .dst_addr, .sta_lo_words, .sta_hi_words,
    .hash_lo, .hash_hi, .mode_copy_all, .mode_mc_hash, .mode_uc_hash,
    .mode_no_bcast, .dec_valid, .dec_accept, .dec_reason
  );

  localparam logic [47:0] A0 = 48'h554433221102;
  localparam logic [47:0] A2 = 48'h66778899AA0C;
  localparam logic [47:0] AX = 48'h554433221103;
  localparam logic [47:0] BC = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] UA = 48'h0123456789A4;
  localparam logic [47:0] MA = 48'h0123456789A5;
  localparam logic [47:0] ZA = 48'h000000000000;

  // {addr, mode{copy,mc,uc,nob}, table select, accept, reason}
  // table select: 0 empty, 1 full, 2 only the indexed bit, 3 all but the indexed bit
  localparam int NV = 22;
  localparam logic [56:0] VEC [NV] = '{
    {A0, 4'b0000, 2'd0, 1'b1, 2'd0},  // R4 station 0
    {A2, 4'b0000, 2'd0, 1'b1, 2'd0},  // R4 station 2
    {AX, 4'b0000, 2'd0, 1'b0, 2'd0},  // R11 near miss
    {BC, 4'b0000, 2'd0, 1'b1, 2'd1},  // R6 broadcast
    {BC, 4'b0001, 2'd0, 1'b0, 2'd0},  // R6 veto
    {BC, 4'b1001, 2'd0, 1'b1, 2'd3},  // R3 copy-all beats veto
    {UA, 4'b1000, 2'd0, 1'b1, 2'd3},  // R3
    {UA, 4'b0000, 2'd0, 1'b0, 2'd0},  // R11
    {MA, 4'b0100, 2'd2, 1'b1, 2'd2},  // R8 own bit
    {MA, 4'b0100, 2'd3, 1'b0, 2'd0},  // R7 other bits only
    {MA, 4'b0100, 2'd1, 1'b1, 2'd2},  // R10 full table
    {MA, 4'b0000, 2'd1, 1'b0, 2'd0},  // R10 hash off
    {UA, 4'b0100, 2'd1, 1'b0, 2'd0},  // R9 group enable on individual
    {UA, 4'b0010, 2'd2, 1'b1, 2'd2},  // R9 individual hash
    {UA, 4'b0010, 2'd3, 1'b0, 2'd0},  // R9 other bits only
    {A0, 4'b0010, 2'd1, 1'b1, 2'd0},  // R11 station beats hash
    {A0, 4'b1000, 2'd0, 1'b1, 2'd3},  // R11 copy-all beats station
    {BC, 4'b0100, 2'd1, 1'b1, 2'd1},  // R11 broadcast beats hash
    {BC, 4'b0100, 2'd1, 1'b0, 2'd0},  // placeholder replaced below by veto row
    {ZA, 4'b0000, 2'd0, 1'b0, 2'd0},  // R5 zero stations never match
    {ZA, 4'b0010, 2'd2, 1'b1, 2'd2},  // R9 zero address, index 0
    {MA, 4'b0010, 2'd1, 1'b0, 2'd0}   // R9 individual enable on group
  };

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int by = 0; by < 6; by++) begin
      for (int bi = 0; bi < 8; bi++) begin
        r[(8*by + bi) % 6] = r[(8*by + bi) % 6] ^ a[8*by + bi];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_table(input logic [47:0] a, input logic [1:0] sel);
    logic [63:0] t;
    logic [63:0] one = 64'd1 << ref_index(a);
    case (sel)
      2'd0: t = '0;
      2'd1: t = '1;
      2'd2: t = one;
      default: t = ~one;
    endcase
    hash_lo = t[31:0];
    hash_hi = t[63:32];
  endtask

  task automatic strobe(input logic [47:0] a, input logic [3:0] m);
    @(negedge clk);
    dst_addr = a;
    {mode_copy_all, mode_mc_hash, mode_uc_hash, mode_no_bcast} = m;
    dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dst_valid = 1'b0;
    dst_addr = '0;
    {mode_copy_all, mode_mc_hash, mode_uc_hash, mode_no_bcast} = 4'b0000;
    hash_lo = '0;
    hash_hi = '0;
    // Stations 0 and 2 programmed, 1 and 3 left at zero.
    sta_lo_words = '0;
    sta_hi_words = '0;
    sta_lo_words[0*32 +: 32] = 32'h33221102;
    sta_hi_words[0*16 +: 16] = 16'h5544;
    sta_lo_words[2*32 +: 32] = 32'h8899AA0C;
    sta_hi_words[2*16 +: 16] = 16'h6677;

    repeat (3) @(negedge clk);
    check("R1 in reset", {dec_valid, dec_accept, dec_reason}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {dec_valid, dec_accept, dec_reason}, 4'b0000);

    // Vector table.
    for (int v = 0; v < NV; v++) begin
      logic [56:0] e = VEC[v];
      if (v == 18) e = {BC, 4'b0101, 2'd1, 1'b0, 2'd0}; // R6 veto beats full table
      load_table(e[56:9], e[4:3]);
      strobe(e[56:9], e[8:5]);
      check($sformatf("R11 vector %0d", v), {dec_valid, dec_accept, dec_reason},
            {1'b1, e[2], e[1:0]});
    end

    // R2: verdict lasts one cycle.
    @(negedge clk);
    check("R2 single cycle", {dec_valid, dec_accept, dec_reason}, 4'b0000);

    // R2: back-to-back strobes.
    hash_lo = '0; hash_hi = '0;
    @(negedge clk);
    {mode_copy_all, mode_mc_hash, mode_uc_hash, mode_no_bcast} = 4'b0000;
    dst_addr = A2; dst_valid = 1'b1;
    @(negedge clk);
    check("R2 first of pair", {dec_valid, dec_accept, dec_reason}, 4'b1100);
    dst_addr = UA;
    @(negedge clk);
    dst_valid = 1'b0;
    check("R2 second of pair", {dec_valid, dec_accept, dec_reason}, 4'b1000);

    // R7: literal index decode. Bits 0 and 5 set give index 33, i.e. hash_hi[1].
    hash_lo = '0; hash_hi = 32'h2;
    strobe(48'h000000000021, 4'b0100);
    check("R7 index 33 high word", {dec_valid, dec_accept, dec_reason}, 4'b1110);
    hash_lo = 32'h2; hash_hi = '0;
    strobe(48'h000000000021, 4'b0100);
    check("R7 index 33 not low word", {dec_valid, dec_accept, dec_reason}, 4'b1000);
    // Byte 1 bit 0 is position 8, folding into index bit 2: index 4.
    hash_lo = 32'h10; hash_hi = '0;
    strobe(48'h000000000100, 4'b0010);
    check("R7 index 4 from byte 1", {dec_valid, dec_accept, dec_reason}, 4'b1110);
    // Byte 0 bit 0 alone: index 1, a group address.
    hash_lo = 32'h2; hash_hi = '0;
    strobe(48'h000000000001, 4'b0100);
    check("R8 index 1 group", {dec_valid, dec_accept, dec_reason}, 4'b1110);

    // R1: reset in flight clears a pending verdict at once.
    hash_lo = '0; hash_hi = '0;
    @(negedge clk);
    dst_addr = A0; dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", {dec_valid, dec_accept, dec_reason}, 4'b0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobe(A0, 4'b0000);
    check("R4 after re-reset", {dec_valid, dec_accept, dec_reason}, 4'b1100);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule